// File: doc/BRIEF.md
# Configuration Pin Refresh Handshake Controller

This block forces an attached FPGA back into its program mode so that a later stage can load a fresh bitstream. When the board has the configuration strobe pins fitted, the block pulls the active-low program strobe low, waits for the active-low init indicator to go low, then waits for the active-high done indicator to drop. It then lets the program strobe go high again and waits for the init indicator to rise. That rise means the target is ready to take a bitstream. Each of the three waits has its own timeout. A timeout in either of the first two waits reports an error and leaves the program strobe held low.

When the pins are not fitted, a strap input selects a fallback path. The block sends a four-byte refresh command over a byte-wide command port with a valid/ready handshake and marks the final byte. It then waits a fixed settle delay before it acknowledges. A single-cycle request starts either sequence. Completion is a single-cycle acknowledge, with an error flag that is valid in the same cycle. Both input pins pass through two-flop synchronisers. The sampling interval, timeout length and settle delay are parameters counted in clock cycles. At 100 MHz, the defaults give a 30 µs sampling interval, a 100 ms timeout and a 6 ms settle delay.

Top module: `cfg_refresh_ctrl`

## Requirements
- R1: After reset the program strobe output is high, and acknowledge, error and command-valid are low.
- R2: A request accepted in the idle state with the pins-fitted strap high drives the program strobe low from the next cycle. The strobe stays low through the init-low and done-low waits.
- R3: The init and done inputs are sampled through a two-flop synchroniser once every SAMPLE_CLKS cycles. A wait ends at the first sample that meets its condition, and the next wait starts counting afresh.
- R4: If the init-low wait sees TIMEOUT_SAMPLES failing samples, the block acknowledges with error SAMPLE_CLKS*TIMEOUT_SAMPLES cycles after the request. The program strobe stays low until the next request.
- R5: If the done-low wait times out, the block acknowledges with error SAMPLE_CLKS*(1+TIMEOUT_SAMPLES) cycles after the request, with the program strobe still low.
- R6: When done is seen low, the program strobe goes high and the block waits for init high. Success gives acknowledge without error 3*SAMPLE_CLKS cycles after the request.
- R7: If the init-high wait times out, the block acknowledges with error SAMPLE_CLKS*(2+TIMEOUT_SAMPLES) cycles after the request, with the program strobe high.
- R8: With the strap low, the block sends the byte sequence 0x79, 0x00, 0x00, 0x00 in that order. Each byte is held with valid asserted until ready is seen. The last flag is high only with the fourth byte.
- R9: In fallback mode the acknowledge comes without error exactly SETTLE_CLKS cycles after the fourth byte is accepted. The program strobe keeps the level it had before the request.
- R10: A request raised while a sequence is running is ignored: the sequence keeps its timing and gives exactly one acknowledge.
- R11: Acknowledge is a single-cycle pulse, and error is high only in an acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start a refresh sequence (sampled in idle) |
| pins_fitted_i | input | 1 | Strap: 1 = strobe pins present, 0 = command fallback |
| ack_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Failure flag, valid with ack_o |
| prog_n_o | output | 1 | Active-low program strobe to the target |
| init_n_i | input | 1 | Active-low init indicator from the target (asynchronous) |
| done_i | input | 1 | Active-high done indicator from the target (asynchronous) |
| cmd_valid_o | output | 1 | Command byte valid |
| cmd_ready_i | input | 1 | Command port accepts the byte |
| cmd_byte_o | output | 8 | Command byte |
| cmd_last_o | output | 1 | Marks the final byte of the command |

## Verification
The hardest cases to reach are the timeouts at each individual phase. The phase-three timeout is the hardest of these: the target must go through the first two steps correctly and then fail to release init. The bench drives a small behavioural target whose three responses (init falls, done falls, init rises again) can each be turned off. It sweeps all eight combinations with small sampling and timeout counts. It checks the acknowledge latency, the error flag and the strobe level against closed-form values. The fallback path is run under several ready-stall patterns, and also after a failed pin sequence, to show that it leaves the strobe level alone.

// File: rtl/cfg_refresh_pkg.sv
package cfg_refresh_pkg;

    localparam int unsigned CMD_BYTES      = 4;
    localparam logic [7:0]  REFRESH_OPCODE = 8'h79;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_INIT_LO,
        ST_WAIT_DONE_LO,
        ST_WAIT_INIT_HI,
        ST_SEND,
        ST_SETTLE
    } refresh_state_e;

    typedef struct packed {
        logic init_n;
        logic done;
    } pin_bus_t;

    function automatic logic [7:0] refresh_byte(input logic [1:0] idx);
        return (idx == 2'd0) ? REFRESH_OPCODE : 8'h00;
    endfunction

    function automatic logic is_pin_wait(input refresh_state_e st);
        return (st == ST_WAIT_INIT_LO) || (st == ST_WAIT_DONE_LO) ||
               (st == ST_WAIT_INIT_HI);
    endfunction

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
    parameter int unsigned     WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= RST_VAL[b];
                sync_q <= RST_VAL[b];
            end else begin
                meta_q <= d_i[b];
                sync_q <= meta_q;
            end
        end
        assign q_o[b] = sync_q;
    end
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
    parameter int unsigned SAMPLE_CLKS     = 3000,
    parameter int unsigned TIMEOUT_SAMPLES = 3334
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic cond_i,
    output logic pass_o,
    output logic expire_o
);
    localparam int unsigned TW = $clog2(SAMPLE_CLKS + 1);
    localparam int unsigned SW = $clog2(TIMEOUT_SAMPLES + 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(SAMPLE_CLKS - 1);
    localparam logic [SW-1:0] SAMP_LAST = SW'(TIMEOUT_SAMPLES - 1);

    logic [TW-1:0] tick_q;
    logic [SW-1:0] samp_q;
    logic          sample;

    assign sample   = en_i && (tick_q == TICK_LAST);
    assign pass_o   = sample && cond_i;
    assign expire_o = sample && !cond_i && (samp_q == SAMP_LAST);

    always_ff @(posedge clk) begin
        if (rst || !en_i || pass_o || expire_o) begin
            tick_q <= '0;
            samp_q <= '0;
        end else if (sample) begin
            tick_q <= '0;
            samp_q <= samp_q + 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    AST_SAMPLE_BOUND: assert property (@(posedge clk) disable iff (rst)
        en_i && !sample |=> samp_q <= SAMP_LAST) else $error("sample count overran"); // R4
endmodule

// File: rtl/cfg_cmd_tx.sv
module cfg_cmd_tx
    import cfg_refresh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       ready_i,
    output logic       valid_o,
    output logic [7:0] byte_o,
    output logic       last_o,
    output logic       done_o
);
    localparam logic [1:0] IDX_LAST = 2'(CMD_BYTES - 1);

    logic       active_q;
    logic [1:0] idx_q;

    assign valid_o = active_q;
    assign byte_o  = active_q ? refresh_byte(idx_q) : 8'h00;
    assign last_o  = active_q && (idx_q == IDX_LAST);
    assign done_o  = last_o && ready_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            idx_q    <= '0;
        end else if (active_q && ready_i) begin
            if (last_o) active_q <= 1'b0;
            else        idx_q    <= idx_q + 1'b1;
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        valid_o && !ready_i |=> valid_o && $stable(byte_o)) else $error("byte dropped"); // R8
    AST_LAST_ONE: assert property (@(posedge clk) disable iff (rst)
        last_o && ready_i |=> !valid_o) else $error("extra byte"); // R8
endmodule

// File: rtl/cfg_refresh_ctrl.sv
module cfg_refresh_ctrl
    import cfg_refresh_pkg::*;
#(
    parameter int unsigned SAMPLE_CLKS     = 3000,
    parameter int unsigned TIMEOUT_SAMPLES = 3334,
    parameter int unsigned SETTLE_CLKS     = 600000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_i,
    input  logic       pins_fitted_i,
    output logic       ack_o,
    output logic       err_o,
    output logic       prog_n_o,
    input  logic       init_n_i,
    input  logic       done_i,
    output logic       cmd_valid_o,
    input  logic       cmd_ready_i,
    output logic [7:0] cmd_byte_o,
    output logic       cmd_last_o
);
    localparam int unsigned CW = $clog2(SETTLE_CLKS + 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CLKS - 1);

    refresh_state_e state_q;
    logic           prog_n_q;
    logic           ack_q;
    logic           err_q;
    logic [CW-1:0]  settle_q;

    pin_bus_t pins_raw, pins_s;
    assign pins_raw.init_n = init_n_i;
    assign pins_raw.done   = done_i;

    cfg_pin_sync #(.WIDTH(2), .RST_VAL(2'b10)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pins_raw),
        .q_o (pins_s)
    );

    logic wait_en, wait_cond, wait_pass, wait_expire;
    assign wait_en = is_pin_wait(state_q);

    always_comb begin
        case (state_q)
            ST_WAIT_INIT_LO: wait_cond = !pins_s.init_n;
            ST_WAIT_DONE_LO: wait_cond = !pins_s.done;
            ST_WAIT_INIT_HI: wait_cond = pins_s.init_n;
            default:         wait_cond = 1'b0;
        endcase
    end

    cfg_wait_timer #(
        .SAMPLE_CLKS     (SAMPLE_CLKS),
        .TIMEOUT_SAMPLES (TIMEOUT_SAMPLES)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .en_i     (wait_en),
        .cond_i   (wait_cond),
        .pass_o   (wait_pass),
        .expire_o (wait_expire)
    );

    logic tx_start, tx_done;
    assign tx_start = (state_q == ST_IDLE) && req_i && !pins_fitted_i;

    cfg_cmd_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .start_i (tx_start),
        .ready_i (cmd_ready_i),
        .valid_o (cmd_valid_o),
        .byte_o  (cmd_byte_o),
        .last_o  (cmd_last_o),
        .done_o  (tx_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            prog_n_q <= 1'b1;
            ack_q    <= 1'b0;
            err_q    <= 1'b0;
            settle_q <= '0;
        end else begin
            ack_q <= 1'b0;
            err_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (req_i) begin
                    if (pins_fitted_i) begin
                        prog_n_q <= 1'b0;
                        state_q  <= ST_WAIT_INIT_LO;
                    end else begin
                        state_q  <= ST_SEND;
                    end
                end
                ST_WAIT_INIT_LO: begin
                    if (wait_pass) state_q <= ST_WAIT_DONE_LO;
                    else if (wait_expire) begin
                        state_q <= ST_IDLE;
                        ack_q   <= 1'b1;
                        err_q   <= 1'b1;
                    end
                end
                ST_WAIT_DONE_LO: begin
                    if (wait_pass) begin
                        prog_n_q <= 1'b1;
                        state_q  <= ST_WAIT_INIT_HI;
                    end else if (wait_expire) begin
                        state_q <= ST_IDLE;
                        ack_q   <= 1'b1;
                        err_q   <= 1'b1;
                    end
                end
                ST_WAIT_INIT_HI: begin
                    if (wait_pass || wait_expire) begin
                        state_q <= ST_IDLE;
                        ack_q   <= 1'b1;
                        err_q   <= wait_expire;
                    end
                end
                ST_SEND: if (tx_done) begin
                    settle_q <= '0;
                    state_q  <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (settle_q == SETTLE_LAST) begin
                        state_q <= ST_IDLE;
                        ack_q   <= 1'b1;
                    end else begin
                        settle_q <= settle_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ack_o    = ack_q;
    assign err_o    = err_q;
    assign prog_n_o = prog_n_q;

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o) else $error("ack longer than one cycle"); // R11
    AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        err_o |-> ack_o) else $error("error without ack"); // R11
    AST_PROG_LOW_EARLY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_INIT_LO || state_q == ST_WAIT_DONE_LO) |-> !prog_n_o)
        else $error("strobe released early"); // R2
    AST_FALLBACK_KEEPS_PROG: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEND || state_q == ST_SETTLE) |=> $stable(prog_n_o))
        else $error("fallback touched strobe"); // R9
    AST_NO_CMD_IN_PIN_MODE: assert property (@(posedge clk) disable iff (rst)
        wait_en |-> !cmd_valid_o) else $error("command during pin wait"); // R10
endmodule

// File: tb/test_cfg_refresh_ctrl.sv
module test_cfg_refresh_ctrl;
    localparam int P = 4;
    localparam int T = 3;
    localparam int S = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic pins_fitted = 1'b1;
    logic ack, err, prog_n, init_n, done;
    logic cmd_valid, cmd_ready, cmd_last;
    logic [7:0] cmd_byte;

    logic m_resp = 1'b1, m_dclr = 1'b1, m_rel = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ncap = 0;
    int last_acc = 0;
    logic [7:0] cap_byte [64];
    logic       cap_last [64];

    always #5 clk = ~clk;

    assign init_n = prog_n ? m_rel : !m_resp;
    assign done   = (!prog_n && m_dclr) ? 1'b0 : 1'b1;

    cfg_refresh_ctrl #(
        .SAMPLE_CLKS(P), .TIMEOUT_SAMPLES(T), .SETTLE_CLKS(S)
    ) i_cfg_refresh_ctrl (
        .clk(clk), .rst(rst), .req_i(req), .pins_fitted_i(pins_fitted),
        .ack_o(ack), .err_o(err), .prog_n_o(prog_n),
        .init_n_i(init_n), .done_i(done),
        .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
        .cmd_byte_o(cmd_byte), .cmd_last_o(cmd_last)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cmd_valid && cmd_ready) begin
            cap_byte[ncap % 64] <= cmd_byte;
            cap_last[ncap % 64] <= cmd_last;
            ncap     <= ncap + 1;
            last_acc <= cyc;
        end
    end

    task automatic chk(input logic ok, input string req_tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp_v);
        end
    endtask

    task automatic run_pins(input logic resp, input logic dclr, input logic rel, input logic poke);
        int lat, exp_lat, extra;
        logic exp_err, exp_prog;
        m_resp = resp; m_dclr = dclr; m_rel = rel;
        pins_fitted = 1'b1;
        if (!resp)      begin exp_lat = T*P;     exp_err = 1; exp_prog = 0; end
        else if (!dclr) begin exp_lat = P + T*P; exp_err = 1; exp_prog = 0; end
        else if (!rel)  begin exp_lat = 2*P+T*P; exp_err = 1; exp_prog = 1; end
        else            begin exp_lat = 3*P;     exp_err = 0; exp_prog = 1; end
        repeat (3) @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(prog_n == 1'b0, "R2 strobe low after request", prog_n, 0);
        lat = 0;
        forever begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (ack) break;
            req = (poke && lat == 5);
            if (lat > 2000) begin
                chk(1'b0, "R3 watchdog on pin run", lat, exp_lat);
                break;
            end
        end
        req = 1'b0;
        if (!resp)      chk(lat == exp_lat, "R4 init-low timeout latency", lat, exp_lat);
        else if (!dclr) chk(lat == exp_lat, "R5 done-low timeout latency", lat, exp_lat);
        else if (!rel)  chk(lat == exp_lat, "R7 init-high timeout latency", lat, exp_lat);
        else            chk(lat == exp_lat, "R6 R3 success latency", lat, exp_lat);
        chk(err == exp_err, "R4 R5 R6 R7 error flag", err, exp_err);
        chk(prog_n == exp_prog, "R4 R5 R6 R7 strobe level at ack", prog_n, exp_prog);
        @(negedge clk);
        chk(ack == 1'b0 && err == 1'b0, "R11 ack single pulse", ack, 0);
        extra = 0;
        repeat (40) begin
            @(negedge clk);
            if (ack) extra++;
        end
        chk(extra == 0, "R10 no further ack", extra, 0);
        chk(prog_n == exp_prog, "R4 strobe held until next request", prog_n, exp_prog);
    endtask

    task automatic run_fallback(input logic [3:0] mask, input logic poke);
        int n0, k, d;
        logic prog_before;
        pins_fitted = 1'b0;
        prog_before = prog_n;
        n0 = ncap;
        k = 0;
        cmd_ready = mask[0];
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        forever begin
            @(posedge clk);
            @(negedge clk);
            if (ack) break;
            k++;
            cmd_ready = mask[k % 4];
            req = (poke && k == 3);
            if (k > 2000) begin
                chk(1'b0, "R9 watchdog on fallback", k, 0);
                break;
            end
        end
        req = 1'b0;
        d = cyc - last_acc - 1;
        chk(ncap - n0 == 4, "R8 byte count", ncap - n0, 4);
        for (int i = 0; i < 4; i++) begin
            int e = (i == 0) ? 8'h79 : 8'h00;
            chk(cap_byte[(n0 + i) % 64] == 8'(e), "R8 byte value", cap_byte[(n0 + i) % 64], e);
            chk(cap_last[(n0 + i) % 64] == (i == 3), "R8 last flag", cap_last[(n0 + i) % 64], (i == 3));
        end
        chk(d == S, "R9 settle delay", d, S);
        chk(err == 1'b0, "R9 no error", err, 0);
        chk(prog_n == prog_before, "R9 strobe untouched", prog_n, prog_before);
        cmd_ready = 1'b0;
        @(negedge clk);
        chk(ack == 1'b0, "R11 ack single pulse fallback", ack, 0);
        repeat (20) begin
            @(negedge clk);
            chk(!ack && !cmd_valid, "R10 no restart after poke", ack, 0);
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cmd_ready = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(prog_n == 1'b1, "R1 strobe high after reset", prog_n, 1);
        chk(ack == 1'b0 && err == 1'b0, "R1 ack and err low", ack, 0);
        chk(cmd_valid == 1'b0, "R1 no command", cmd_valid, 0);

        run_fallback(4'b1111, 1'b0);
        for (int s = 0; s < 8; s++) begin
            run_pins(s[2], s[1], s[0], 1'b0);
        end
        run_pins(1'b1, 1'b1, 1'b1, 1'b1);
        run_pins(1'b0, 1'b1, 1'b1, 1'b1);
        run_fallback(4'b0101, 1'b1);
        run_fallback(4'b1000, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule